// File: doc/BRIEF.md
# Active Priority Tracker

This block keeps, for one CPU interface of an interrupt controller, a record of which preemption levels are currently active. Each interrupt group (group 0, secure group 1, non-secure group 1) has a bank of 32-bit words, one bit per preemption level. When an interrupt is acknowledged, the bit for its group priority is set. When it ends, the lowest-numbered set bit of that group's bank is cleared (priority drop). The running priority is derived from all banks and is output continuously.

The number of implemented priority bits is a parameter (4 to 8). It sets the preemption bit count, the number of words per bank, the mapping from priority to bit index, and the floor of each binary point register. The block also holds the binary point registers and the priority mask register, because both depend on the same parameter. A word port lets software save and restore each bank word.

Top module: `active_prio_tracker`

## Requirements
- R1: With PRI_BITS priority bits, the preemption bit count PRE is PRI_BITS, or 7 when PRI_BITS is 8. Each bank holds 2^(PRE-5) words, and never fewer than 1. Only the lowest 2^PRE bit positions of a bank are implemented.
- R2: After reset, every bank word reads zero and runPrio is 0xFF. pmrOut is 0. bprG0 and bprG1S are 7-PRE, and bprG1NS is 8-PRE.
- R3: Group codes are 0 = group 0, 1 = secure group 1 and 2 = non-secure group 1. An acknowledge sets one bit in the named group's bank. The group mask is 0xFF shifted left by (b+1), where b is that group's binary point, or that binary point minus 1 for code 2. The bit index is (ackPrio AND group mask) shifted right by (8-PRE). Word index/32 holds that bit, at position index mod 32.
- R4: runPrio is the lowest set bit index taken over the OR of all three banks, shifted left by (8-PRE). It is 0xFF when no bit is set. A change is visible in the cycle after the clock edge that makes it.
- R5: An end-of-interrupt clears only the lowest set bit of the requesting group's bank, scanning from word 0 upward. With no bit set it does nothing.
- R6: A word write replaces word aprSel of bank aprGroup. Bits beyond the implemented positions are stored as zero. aprRdData returns the addressed word combinationally. Word indices at or above the word count are ignored on write and read as zero.
- R7: A binary point write below the group's floor stores the floor. The floor is 7-PRE for codes 0 and 1 and 8-PRE for code 2. Values at or above the floor are stored unchanged.
- R8: A priority mask write is ANDed with (0xFF << (8-PRI_BITS)) & 0xFF. When pmrNsRestricted is high, the data is first turned into (data >> 1) | 0x80.
- R9: Group code 3 on any acknowledge, end-of-interrupt, word or binary point access has no effect, and a word read with code 3 returns zero.
- R10: At most one bank operation takes effect per cycle. A word write request (aprWrEn) blocks end-of-interrupt and acknowledge, and end-of-interrupt blocks acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ackValid | input | 1 | Acknowledge strobe |
| ackGroup | input | 2 | Group code of acknowledged interrupt |
| ackPrio | input | 8 | Priority of acknowledged interrupt |
| eoiValid | input | 1 | End-of-interrupt (priority drop) strobe |
| eoiGroup | input | 2 | Group code for the drop |
| aprWrEn | input | 1 | Bank word write strobe |
| aprGroup | input | 2 | Bank selected for word write/read |
| aprSel | input | 2 | Word index within the bank |
| aprWrData | input | 32 | Word write data |
| aprRdData | output | 32 | Addressed word |
| bprWrEn | input | 1 | Binary point write strobe |
| bprGroup | input | 2 | Binary point register selected |
| bprWrData | input | 3 | Binary point write data |
| pmrWrEn | input | 1 | Priority mask write strobe |
| pmrNsRestricted | input | 1 | Write comes from the non-secure side while group 0 is secure-only |
| pmrWrData | input | 8 | Priority mask write data |
| bprG0 | output | 3 | Group 0 binary point |
| bprG1S | output | 3 | Secure group 1 binary point |
| bprG1NS | output | 3 | Non-secure group 1 binary point |
| pmrOut | output | 8 | Priority mask |
| runPrio | output | 8 | Running priority |

## Verification
The checker assumes that each strobe lasts one clean cycle and that ackPrio, group codes and write data are steady around the sampling edge. It also assumes reset is asserted from time zero. The bench drives every strobe just after a falling edge and clears it one cycle later, so each operation meets exactly one rising edge. Two instances, one with 5 and one with 8 priority bits, share the same stimulus. This exercises both the single-word bank and the four-word bank, with the word split, under identical sequences. Same-cycle collisions are produced on purpose, and only in the scenario that checks the ordering rule.

// File: rtl/apt_pkg.sv
package apt_pkg;

  typedef enum logic [1:0] {
    GRP_G0   = 2'd0,
    GRP_G1S  = 2'd1,
    GRP_G1NS = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  localparam int NUM_GROUPS = 3;

  // control to datapath strobes; widths sized for the largest configuration
  typedef struct packed {
    logic        setEn;
    logic [1:0]  setGrp;
    logic [6:0]  setIdx;
    logic        dropEn;
    logic [1:0]  dropGrp;
    logic        wordWrEn;
    logic [1:0]  wordGrp;
    logic [1:0]  wordSel;
    logic [31:0] wordData;
    logic        bprWrEn;
    logic [1:0]  bprGrp;
    logic [2:0]  bprVal;
    logic        pmrWrEn;
    logic [7:0]  pmrVal;
  } apt_strobe_t;

  function automatic int preOf(input int pri);
    return (pri == 8) ? 7 : pri;
  endfunction

  function automatic int wordsOf(input int pre);
    return (pre <= 5) ? 1 : (1 << (pre - 5));
  endfunction

endpackage

// File: rtl/apt_ctrl.sv
module apt_ctrl
  import apt_pkg::*;
#(
  parameter int PRI_BITS = 5
) (
  input  logic        ackValid,
  input  logic [1:0]  ackGroup,
  input  logic [7:0]  ackPrio,
  input  logic        eoiValid,
  input  logic [1:0]  eoiGroup,
  input  logic        aprWrEn,
  input  logic [1:0]  aprGroup,
  input  logic [1:0]  aprSel,
  input  logic [31:0] aprWrData,
  input  logic        bprWrEn,
  input  logic [1:0]  bprGroup,
  input  logic [2:0]  bprWrData,
  input  logic        pmrWrEn,
  input  logic        pmrNsRestricted,
  input  logic [7:0]  pmrWrData,
  input  logic [2:0]  bprG0,
  input  logic [2:0]  bprG1S,
  input  logic [2:0]  bprG1NS,
  output apt_strobe_t strb
);

  localparam int PRE       = preOf(PRI_BITS);
  localparam int NUM_WORDS = wordsOf(PRE);
  localparam int SHIFT     = 8 - PRE;
  localparam logic [2:0] MIN_BPR    = 3'(7 - PRE);
  localparam logic [2:0] MIN_BPR_NS = 3'(8 - PRE);
  localparam logic [7:0] FULL_MASK  = 8'((8'hFF << (8 - PRI_BITS)) & 8'hFF);

  logic [3:0] bprEff;
  logic [7:0] groupMask;
  logic [7:0] groupPrio;
  logic [7:0] bitIndex;
  logic [2:0] bprFloor;
  logic [7:0] pmrRaw;
  logic       ackGrpOk, eoiGrpOk, aprGrpOk, bprGrpOk, aprSelOk;

  always_comb begin
    ackGrpOk = (ackGroup != GRP_NONE);
    eoiGrpOk = (eoiGroup != GRP_NONE);
    aprGrpOk = (aprGroup != GRP_NONE);
    bprGrpOk = (bprGroup != GRP_NONE);
    aprSelOk = ({1'b0, aprSel} < 3'(NUM_WORDS));

    // effective binary point for the group priority split
    unique case (ackGroup)
      GRP_G0:   bprEff = {1'b0, bprG0};
      GRP_G1S:  bprEff = {1'b0, bprG1S};
      GRP_G1NS: bprEff = (bprG1NS == 3'd0) ? 4'd0 : ({1'b0, bprG1NS} - 4'd1);
      default:  bprEff = 4'd0;
    endcase
    groupMask = 8'hFF << (bprEff + 4'd1);
    groupPrio = ackPrio & groupMask;
    bitIndex  = groupPrio >> SHIFT;

    bprFloor = (bprGroup == GRP_G1NS) ? MIN_BPR_NS : MIN_BPR;
    pmrRaw   = pmrNsRestricted ? {1'b1, pmrWrData[7:1]} : pmrWrData;

    strb          = '0;
    strb.wordWrEn = aprWrEn && aprGrpOk && aprSelOk;
    strb.wordGrp  = aprGroup;
    strb.wordSel  = aprSel;
    strb.wordData = aprWrData;
    strb.dropEn   = !aprWrEn && eoiValid && eoiGrpOk;
    strb.dropGrp  = eoiGroup;
    strb.setEn    = !aprWrEn && !eoiValid && ackValid && ackGrpOk;
    strb.setGrp   = ackGroup;
    strb.setIdx   = bitIndex[6:0];
    strb.bprWrEn  = bprWrEn && bprGrpOk;
    strb.bprGrp   = bprGroup;
    strb.bprVal   = (bprWrData < bprFloor) ? bprFloor : bprWrData;
    strb.pmrWrEn  = pmrWrEn;
    strb.pmrVal   = pmrRaw & FULL_MASK;
  end

  logic unusedIdxTop;
  assign unusedIdxTop = bitIndex[7];

endmodule

// File: rtl/apt_datapath.sv
module apt_datapath
  import apt_pkg::*;
#(
  parameter int PRI_BITS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  apt_strobe_t strb,
  input  logic [1:0]  aprGroup,
  input  logic [1:0]  aprSel,
  output logic [31:0] aprRdData,
  output logic [2:0]  bprG0,
  output logic [2:0]  bprG1S,
  output logic [2:0]  bprG1NS,
  output logic [7:0]  pmrOut,
  output logic [7:0]  runPrio
);

  localparam int PRE       = preOf(PRI_BITS);
  localparam int NUM_WORDS = wordsOf(PRE);
  localparam int NUM_IDX   = 1 << PRE;
  localparam int BANK_W    = NUM_WORDS * 32;
  localparam int SHIFT     = 8 - PRE;
  localparam logic [2:0] MIN_BPR    = 3'(7 - PRE);
  localparam logic [2:0] MIN_BPR_NS = 3'(8 - PRE);
  localparam logic [BANK_W-1:0] IMPL_MASK = {BANK_W{1'b1}} >> (BANK_W - NUM_IDX);

  logic [BANK_W-1:0] bankView [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
    logic [BANK_W-1:0] words;
    logic [BANK_W-1:0] wordsNxt;

    always_comb begin
      wordsNxt = words;
      if (strb.wordWrEn && (strb.wordGrp == 2'(g))) begin
        for (int w = 0; w < NUM_WORDS; w++) begin
          if (strb.wordSel == 2'(w))
            wordsNxt[w*32 +: 32] = strb.wordData & IMPL_MASK[w*32 +: 32];
        end
      end else if (strb.dropEn && (strb.dropGrp == 2'(g))) begin
        // clear the lowest set bit only
        wordsNxt = words & (words - BANK_W'(1));
      end else if (strb.setEn && (strb.setGrp == 2'(g))) begin
        wordsNxt = words | (BANK_W'(1) << strb.setIdx);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) words <= '0;
      else        words <= wordsNxt;
    end

    assign bankView[g] = words;
  end

  // running priority from the lowest active level across groups
  logic [BANK_W-1:0] activeAny;
  logic [6:0]        firstIdx;
  logic              anyActive;

  always_comb begin
    activeAny = bankView[0] | bankView[1] | bankView[2];
    firstIdx  = '0;
    anyActive = 1'b0;
    for (int i = NUM_IDX - 1; i >= 0; i--) begin
      if (activeAny[i]) begin
        firstIdx  = 7'(i);
        anyActive = 1'b1;
      end
    end
    runPrio = anyActive ? (8'(firstIdx) << SHIFT) : 8'hFF;
  end

  // word read port
  always_comb begin
    aprRdData = '0;
    if (aprGroup != GRP_NONE) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (aprSel == 2'(w))
          aprRdData = bankView[aprGroup][w*32 +: 32];
      end
    end
  end

  // binary point and priority mask registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bprG0   <= MIN_BPR;
      bprG1S  <= MIN_BPR;
      bprG1NS <= MIN_BPR_NS;
      pmrOut  <= 8'h00;
    end else begin
      if (strb.bprWrEn) begin
        unique case (strb.bprGrp)
          GRP_G0:   bprG0   <= strb.bprVal;
          GRP_G1S:  bprG1S  <= strb.bprVal;
          GRP_G1NS: bprG1NS <= strb.bprVal;
          default:  ;
        endcase
      end
      if (strb.pmrWrEn) pmrOut <= strb.pmrVal;
    end
  end

endmodule

// File: rtl/active_prio_tracker.sv
module active_prio_tracker
  import apt_pkg::*;
#(
  parameter int PRI_BITS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ackValid,
  input  logic [1:0]  ackGroup,
  input  logic [7:0]  ackPrio,
  input  logic        eoiValid,
  input  logic [1:0]  eoiGroup,
  input  logic        aprWrEn,
  input  logic [1:0]  aprGroup,
  input  logic [1:0]  aprSel,
  input  logic [31:0] aprWrData,
  output logic [31:0] aprRdData,
  input  logic        bprWrEn,
  input  logic [1:0]  bprGroup,
  input  logic [2:0]  bprWrData,
  input  logic        pmrWrEn,
  input  logic        pmrNsRestricted,
  input  logic [7:0]  pmrWrData,
  output logic [2:0]  bprG0,
  output logic [2:0]  bprG1S,
  output logic [2:0]  bprG1NS,
  output logic [7:0]  pmrOut,
  output logic [7:0]  runPrio
);

  if (PRI_BITS < 4 || PRI_BITS > 8) begin : g_bad_param
    $error("PRI_BITS must be within 4..8");
  end

  apt_strobe_t strb;

  apt_ctrl #(.PRI_BITS(PRI_BITS)) u_ctrl (
    .ackValid        (ackValid),
    .ackGroup        (ackGroup),
    .ackPrio         (ackPrio),
    .eoiValid        (eoiValid),
    .eoiGroup        (eoiGroup),
    .aprWrEn         (aprWrEn),
    .aprGroup        (aprGroup),
    .aprSel          (aprSel),
    .aprWrData       (aprWrData),
    .bprWrEn         (bprWrEn),
    .bprGroup        (bprGroup),
    .bprWrData       (bprWrData),
    .pmrWrEn         (pmrWrEn),
    .pmrNsRestricted (pmrNsRestricted),
    .pmrWrData       (pmrWrData),
    .bprG0           (bprG0),
    .bprG1S          (bprG1S),
    .bprG1NS         (bprG1NS),
    .strb            (strb)
  );

  apt_datapath #(.PRI_BITS(PRI_BITS)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .aprGroup  (aprGroup),
    .aprSel    (aprSel),
    .aprRdData (aprRdData),
    .bprG0     (bprG0),
    .bprG1S    (bprG1S),
    .bprG1NS   (bprG1NS),
    .pmrOut    (pmrOut),
    .runPrio   (runPrio)
  );

endmodule

// File: rtl/apt_chk.sv
module apt_chk
  import apt_pkg::*;
#(
  parameter int PRI_BITS = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ackValid,
  input logic [1:0] ackGroup,
  input logic       eoiValid,
  input logic       aprWrEn,
  input logic       pmrWrEn,
  input logic [2:0] bprG0,
  input logic [2:0] bprG1S,
  input logic [2:0] bprG1NS,
  input logic [7:0] pmrOut,
  input logic [7:0] runPrio
);

  localparam int PRE = preOf(PRI_BITS);
  localparam logic [7:0] LOW_MASK  = 8'((1 << (8 - PRE)) - 1);
  localparam logic [7:0] FULL_MASK = 8'((8'hFF << (8 - PRI_BITS)) & 8'hFF);
  localparam logic [2:0] MIN_BPR   = 3'(7 - PRE);

  a_r2_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> runPrio == 8'hFF);

  a_r3_ack_activates: assert property (@(posedge clk) disable iff (!rst_n)
    (ackValid && ackGroup != GRP_NONE && !eoiValid && !aprWrEn) |=> runPrio != 8'hFF);

  a_r4_level_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    runPrio != 8'hFF |-> (runPrio & LOW_MASK) == 8'h00);

  a_r4_hold_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ackValid && !eoiValid && !aprWrEn) |=> $stable(runPrio));

  a_r5_drop_never_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (eoiValid && !aprWrEn) |=> runPrio >= $past(runPrio));

  a_r7_bpr_floor: assert property (@(posedge clk) disable iff (!rst_n)
    bprG0 >= MIN_BPR && bprG1S >= MIN_BPR && bprG1NS >= MIN_BPR + 3'd1);

  a_r8_pmr_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (pmrOut & ~FULL_MASK) == 8'h00);

  a_r8_pmr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pmrWrEn |=> $stable(pmrOut));

endmodule

bind active_prio_tracker apt_chk #(.PRI_BITS(PRI_BITS)) u_apt_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ackValid (ackValid),
  .ackGroup (ackGroup),
  .eoiValid (eoiValid),
  .aprWrEn  (aprWrEn),
  .pmrWrEn  (pmrWrEn),
  .bprG0    (bprG0),
  .bprG1S   (bprG1S),
  .bprG1NS  (bprG1NS),
  .pmrOut   (pmrOut),
  .runPrio  (runPrio)
);

// File: tb/tb_active_prio_tracker.sv
module tb_active_prio_tracker;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ackValid, eoiValid, aprWrEn, bprWrEn, pmrWrEn, pmrNsRestricted;
  logic [1:0] ackGroup, eoiGroup, aprGroup, aprSel, bprGroup;
  logic [7:0] ackPrio, pmrWrData;
  logic [31:0] aprWrData;
  logic [2:0] bprWrData;

  logic [31:0] rdN, rdW;
  logic [2:0] b0N, b1N, b2N, b0W, b1W, b2W;
  logic [7:0] pmrN, pmrW, runN, runW;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // 5 priority bits: one word per bank
  active_prio_tracker #(.PRI_BITS(5)) dut (
    .clk(clk), .rst_n(rst_n), .ackValid(ackValid), .ackGroup(ackGroup), .ackPrio(ackPrio),
    .eoiValid(eoiValid), .eoiGroup(eoiGroup), .aprWrEn(aprWrEn), .aprGroup(aprGroup),
    .aprSel(aprSel), .aprWrData(aprWrData), .aprRdData(rdN), .bprWrEn(bprWrEn),
    .bprGroup(bprGroup), .bprWrData(bprWrData), .pmrWrEn(pmrWrEn),
    .pmrNsRestricted(pmrNsRestricted), .pmrWrData(pmrWrData), .bprG0(b0N),
    .bprG1S(b1N), .bprG1NS(b2N), .pmrOut(pmrN), .runPrio(runN));

  // 8 priority bits: four words per bank
  active_prio_tracker #(.PRI_BITS(8)) dutWide (
    .clk(clk), .rst_n(rst_n), .ackValid(ackValid), .ackGroup(ackGroup), .ackPrio(ackPrio),
    .eoiValid(eoiValid), .eoiGroup(eoiGroup), .aprWrEn(aprWrEn), .aprGroup(aprGroup),
    .aprSel(aprSel), .aprWrData(aprWrData), .aprRdData(rdW), .bprWrEn(bprWrEn),
    .bprGroup(bprGroup), .bprWrData(bprWrData), .pmrWrEn(pmrWrEn),
    .pmrNsRestricted(pmrNsRestricted), .pmrWrData(pmrWrData), .bprG0(b0W),
    .bprG1S(b1W), .bprG1NS(b2W), .pmrOut(pmrW), .runPrio(runW));

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ackValid = 0; eoiValid = 0; aprWrEn = 0; bprWrEn = 0; pmrWrEn = 0;
    pmrNsRestricted = 0;
  endtask

  task automatic cycle();
    @(negedge clk);
    idle();
  endtask

  task automatic doAck(input logic [1:0] g, input logic [7:0] p);
    ackValid = 1; ackGroup = g; ackPrio = p; cycle();
  endtask

  task automatic doEoi(input logic [1:0] g);
    eoiValid = 1; eoiGroup = g; cycle();
  endtask

  task automatic doWord(input logic [1:0] g, input logic [1:0] s, input logic [31:0] d);
    aprWrEn = 1; aprGroup = g; aprSel = s; aprWrData = d; cycle();
  endtask

  task automatic doBpr(input logic [1:0] g, input logic [2:0] v);
    bprWrEn = 1; bprGroup = g; bprWrData = v; cycle();
  endtask

  task automatic readWord(input logic [1:0] g, input logic [1:0] s);
    aprGroup = g; aprSel = s; #1;
  endtask

  task automatic testReset();
    check("R2", "runPrio narrow", runN, 8'hFF);
    check("R2", "runPrio wide", runW, 8'hFF);
    check("R2", "pmr narrow", pmrN, 0);
    check("R2", "pmr wide", pmrW, 0);
    check("R1", "bpr floors narrow", {b0N, b1N, b2N}, {3'd2, 3'd2, 3'd3});
    check("R1", "bpr floors wide", {b0W, b1W, b2W}, {3'd0, 3'd0, 3'd1});
    readWord(2'd0, 2'd0);
    check("R2", "word0 after reset", rdN, 0);
  endtask

  task automatic testAck();
    doAck(2'd0, 8'h48);
    check("R3", "run after g0 ack narrow", runN, 8'h48);
    check("R3", "run after g0 ack wide", runW, 8'h48);
    readWord(2'd0, 2'd0);
    check("R3", "g0 word0 narrow bit9", rdN, 32'h200);
    check("R3", "g0 word0 wide empty", rdW, 0);
    readWord(2'd0, 2'd1);
    check("R3", "g0 word1 wide bit4", rdW, 32'h10);
    doAck(2'd2, 8'h20);
    check("R4", "run lowest across groups narrow", runN, 8'h20);
    check("R4", "run lowest across groups wide", runW, 8'h20);
    readWord(2'd2, 2'd0);
    check("R3", "g1ns mask narrow bit4", rdN, 32'h10);
    check("R3", "g1ns mask wide bit16", rdW, 32'h10000);
  endtask

  task automatic testDrop();
    doEoi(2'd0);
    check("R5", "drop g0 narrow", runN, 8'h20);
    check("R5", "drop g0 wide", runW, 8'h20);
    doEoi(2'd0);
    check("R5", "drop on empty bank narrow", runN, 8'h20);
    check("R5", "drop on empty bank wide", runW, 8'h20);
    doEoi(2'd2);
    check("R4", "idle after last drop", runN, 8'hFF);
    doAck(2'd1, 8'h80);
    doAck(2'd1, 8'h40);
    check("R4", "nested run narrow", runN, 8'h40);
    check("R4", "nested run wide", runW, 8'h40);
    readWord(2'd1, 2'd2);
    check("R1", "wide word2 holds level 64", rdW, 32'h1);
    doEoi(2'd1);
    check("R5", "drop clears lowest only narrow", runN, 8'h80);
    check("R5", "drop clears lowest only wide", runW, 8'h80);
    doEoi(2'd1);
    check("R5", "second drop narrow", runN, 8'hFF);
    check("R5", "second drop wide", runW, 8'hFF);
  endtask

  task automatic testBpr();
    doBpr(2'd0, 3'd0);
    check("R7", "g0 clamp narrow", b0N, 2);
    check("R7", "g0 no clamp wide", b0W, 0);
    doBpr(2'd2, 3'd1);
    check("R7", "g1ns clamp narrow", b2N, 3);
    check("R7", "g1ns at floor wide", b2W, 1);
    doBpr(2'd1, 3'd7);
    check("R7", "g1s above floor", {b1N, b1W}, {3'd7, 3'd7});
    doBpr(2'd0, 3'd5);
    doAck(2'd0, 8'h5C);
    check("R3", "coarse group mask narrow", runN, 8'h40);
    check("R3", "coarse group mask wide", runW, 8'h40);
    doEoi(2'd0);
    check("R5", "cleanup drop", runN, 8'hFF);
    doBpr(2'd0, 3'd0);
    doBpr(2'd1, 3'd0);
    check("R7", "restored floors narrow", {b0N, b1N}, {3'd2, 3'd2});
    check("R7", "restored floors wide", {b0W, b1W}, {3'd0, 3'd0});
  endtask

  task automatic testPmr();
    pmrWrEn = 1; pmrWrData = 8'hFF; cycle();
    check("R8", "pmr masked narrow", pmrN, 8'hF8);
    check("R8", "pmr full wide", pmrW, 8'hFF);
    pmrWrEn = 1; pmrNsRestricted = 1; pmrWrData = 8'h47; cycle();
    check("R8", "pmr ns transform narrow", pmrN, 8'hA0);
    check("R8", "pmr ns transform wide", pmrW, 8'hA3);
  endtask

  task automatic testWords();
    doWord(2'd1, 2'd0, 32'h0001_0000);
    check("R6", "restored word run narrow", runN, 8'h80);
    check("R6", "restored word run wide", runW, 8'h20);
    readWord(2'd1, 2'd0);
    check("R6", "readback narrow", rdN, 32'h0001_0000);
    check("R6", "readback wide", rdW, 32'h0001_0000);
    doWord(2'd1, 2'd1, 32'h1);
    readWord(2'd1, 2'd1);
    check("R6", "out of range word reads zero", rdN, 0);
    check("R6", "word1 stored wide", rdW, 32'h1);
    doWord(2'd1, 2'd0, 32'h0);
    check("R6", "cleared word narrow", runN, 8'hFF);
    check("R6", "word1 level wide", runW, 8'h40);
    doWord(2'd1, 2'd1, 32'h0);
    check("R6", "all clear wide", runW, 8'hFF);
  endtask

  task automatic testInvalid();
    doAck(2'd3, 8'h00);
    check("R9", "ack code 3 narrow", runN, 8'hFF);
    check("R9", "ack code 3 wide", runW, 8'hFF);
    doBpr(2'd3, 3'd7);
    check("R9", "bpr code 3 narrow", {b0N, b1N, b2N}, {3'd2, 3'd2, 3'd3});
    check("R9", "bpr code 3 wide", {b0W, b1W, b2W}, {3'd0, 3'd0, 3'd1});
    doWord(2'd3, 2'd0, 32'hFFFF_FFFF);
    check("R9", "word code 3 run", runN, 8'hFF);
    readWord(2'd3, 2'd0);
    check("R9", "read code 3 zero", rdN, 0);
    readWord(2'd0, 2'd0);
    check("R9", "g0 untouched", rdN, 0);
  endtask

  task automatic testOrdering();
    doAck(2'd0, 8'h10);
    check("R10", "setup run narrow", runN, 8'h10);
    check("R10", "setup run wide", runW, 8'h10);
    eoiValid = 1; eoiGroup = 2'd0; ackValid = 1; ackGroup = 2'd0; ackPrio = 8'h08; cycle();
    check("R10", "eoi beats ack narrow", runN, 8'hFF);
    check("R10", "eoi beats ack wide", runW, 8'hFF);
    aprWrEn = 1; aprGroup = 2'd0; aprSel = 2'd0; aprWrData = 32'h8;
    eoiValid = 1; eoiGroup = 2'd0; ackValid = 1; ackGroup = 2'd0; ackPrio = 8'h00; cycle();
    check("R10", "word write beats all narrow", runN, 8'h18);
    check("R10", "word write beats all wide", runW, 8'h06);
    doWord(2'd0, 2'd0, 32'h0);
    check("R10", "cleanup", runN, 8'hFF);
  endtask

  initial begin
    idle();
    ackGroup = 0; ackPrio = 0; eoiGroup = 0; aprGroup = 0; aprSel = 0; aprWrData = 0;
    bprGroup = 0; bprWrData = 0; pmrWrData = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testAck();
    testDrop();
    testBpr();
    testPmr();
    testWords();
    testInvalid();
    testOrdering();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule